// File: doc/BRIEF.md
# Loadable Add/Subtract Register

This block is a registered arithmetic unit of parameterised width. Each enabled clock it stores either the sum of two operands or the difference "second operand minus first operand", chosen cycle by cycle by a single mode input. The datapath is built from visible pieces:

- a conditional inverter on the first operand;
- a ripple carry chain whose entry carry is the mode input itself;
- per-bit three-input XOR sum cells;
- per-bit majority carry cells.

Instead of the arithmetic result, the register can also take a parallel word. This load is synchronous, and it wins over arithmetic whenever the clock enable is high. The carry out of the top bit is captured with the result. A synchronous active-high reset clears both the result and the captured carry. Typical uses are an accumulator, a loop counter with preset, or any register that alternately adds, subtracts and is re-initialised.

Top module: `addsub_loadreg`

## Requirements
- R1: With `rst` high at a rising clock edge, `result` and `carry_out` are both 0 after that edge, whatever the other inputs are.
- R2: With `rst` low, `en` high, `ld` low and `sub` = 0, after the edge `result` = (`opb` + `opa`) mod 2^WIDTH and `carry_out` = bit WIDTH of the unsigned sum.
- R3: With `rst` low, `en` high, `ld` low and `sub` = 1, after the edge `result` = (`opb` − `opa`) mod 2^WIDTH, formed as `opb` + ~`opa` + 1. `carry_out` is 1 exactly when `opb` ≥ `opa` as unsigned numbers.
- R4: With `rst` low, `en` high and `ld` high, after the edge `result` = `ld_data` and `carry_out` = 0, whatever `sub`, `opa` and `opb` are.
- R5: With `rst` low and `en` low, `result` and `carry_out` keep their values across the edge, whatever `ld`, `sub` and the data inputs are.
- R6: Outputs change only at a rising clock edge. Changing `ld`, `ld_data` or the operands between edges leaves `result` and `carry_out` unchanged until the next edge.
- R7: Reset wins over a low enable: `rst` high with `en` low still clears both outputs at the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the result register |
| sub | input | 1 | Mode: 0 adds, 1 computes opb minus opa |
| ld | input | 1 | Synchronous load strobe |
| ld_data | input | WIDTH | Word taken on a load |
| opa | input | WIDTH | First operand (the one inverted in subtract mode) |
| opb | input | WIDTH | Second operand |
| result | output | WIDTH | Registered result |
| carry_out | output | 1 | Registered carry out of the top bit |

## Verification
The bench builds the block with WIDTH = 8. This keeps every wrap-around, borrow and full carry-ripple case within reach of a short directed list plus a few hundred random cycles. The directed list covers 0xFF + 0x01, 0x00 − 0x01, equal operands in subtract mode and subtraction of zero, so that the carry seed and the top-bit carry are each seen at both values. The random cycles mix enable, load and mode together, which exercises every priority between reset, enable, load and arithmetic against the behavioural model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } arith_mode_e;

    typedef enum logic [1:0] {
        NEXT_HOLD  = 2'd0,
        NEXT_LOAD  = 2'd1,
        NEXT_ARITH = 2'd2,
        NEXT_CLEAR = 2'd3
    } next_sel_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } bit_out_t;

    function automatic logic xor3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // Reset first, then enable, then load over arithmetic.
    function automatic next_sel_e pick_next(input logic rst_i, input logic en_i,
                                            input logic ld_i);
        if (rst_i)      return NEXT_CLEAR;
        else if (!en_i) return NEXT_HOLD;
        else if (ld_i)  return NEXT_LOAD;
        else            return NEXT_ARITH;
    endfunction

endpackage

// File: rtl/operand_cond.sv
module operand_cond
    import addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  arith_mode_e      mode,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out
);
    logic flip;
    assign flip = (mode == MODE_SUB);

    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign a_out[i] = a_in[i] ^ flip;
    end
endmodule

// File: rtl/bit_cell.sv
module bit_cell
    import addsub_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     cin,
    output bit_out_t o
);
    always_comb begin
        o.sum   = xor3(a, b, cin);
        o.carry = maj3(a, b, cin);
    end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain
    import addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             seed,
    output logic [WIDTH-1:0] sum,
    output logic             carry_top
);
    logic [WIDTH:0] chain;
    assign chain[0] = seed;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bit_out_t cell_o;
        bit_cell u_cell (
            .a   (a[i]),
            .b   (b[i]),
            .cin (chain[i]),
            .o   (cell_o)
        );
        assign sum[i]     = cell_o.sum;
        assign chain[i+1] = cell_o.carry;
    end

    assign carry_top = chain[WIDTH];
endmodule

// File: rtl/result_reg.sv
module result_reg
    import addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  next_sel_e        sel,
    input  logic [WIDTH-1:0] load_word,
    input  logic [WIDTH-1:0] arith_word,
    input  logic             arith_carry,
    output logic [WIDTH-1:0] q,
    output logic             q_carry
);
    always_ff @(posedge clk) begin
        unique case (sel)
            NEXT_CLEAR: begin
                q       <= '0;
                q_carry <= 1'b0;
            end
            NEXT_LOAD: begin
                q       <= load_word;
                q_carry <= 1'b0;
            end
            NEXT_ARITH: begin
                q       <= arith_word;
                q_carry <= arith_carry;
            end
            default: begin
                q       <= q;
                q_carry <= q_carry;
            end
        endcase
    end
endmodule

// File: rtl/addsub_loadreg.sv
module addsub_loadreg
    import addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             sub,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_data,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    arith_mode_e      mode;
    logic [WIDTH-1:0] a_cond;
    logic [WIDTH-1:0] sum_w;
    logic             carry_w;
    next_sel_e        sel;

    assign mode = arith_mode_e'(sub);
    assign sel  = pick_next(rst, en, ld);

    operand_cond #(.WIDTH(WIDTH)) u_cond (
        .mode  (mode),
        .a_in  (opa),
        .a_out (a_cond)
    );

    // The mode bit is both the inversion control and the carry seed.
    ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a         (a_cond),
        .b         (opb),
        .seed      (sub),
        .sum       (sum_w),
        .carry_top (carry_w)
    );

    result_reg #(.WIDTH(WIDTH)) u_reg (
        .clk         (clk),
        .sel         (sel),
        .load_word   (ld_data),
        .arith_word  (sum_w),
        .arith_carry (carry_w),
        .q           (result),
        .q_carry     (carry_out)
    );
endmodule

// File: rtl/addsub_loadreg_chk.sv
module addsub_loadreg_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             sub,
    input logic             ld,
    input logic [WIDTH-1:0] ld_data,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (result == '0) && !carry_out);

    a_r7_reset_over_hold: assert property (@(posedge clk)
        (rst && !en) |=> (result == '0) && !carry_out);

    a_r2_add_result: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && !sub) |=>
        ({carry_out, result} == ($past({1'b0, opb}) + $past({1'b0, opa}))));

    a_r3_sub_result: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && sub) |=>
        ({carry_out, result} == ($past({1'b0, opb}) + $past({1'b0, ~opa}) + 1'b1)));

    a_r4_load_word: assert property (@(posedge clk) disable iff (rst)
        (en && ld) |=> (result == $past(ld_data)) && !carry_out);

    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(result) && $stable(carry_out));
endmodule

bind addsub_loadreg addsub_loadreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .sub       (sub),
    .ld        (ld),
    .ld_data   (ld_data),
    .opa       (opa),
    .opb       (opb),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/addsub_loadreg_test.sv
module addsub_loadreg_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0, sub = 1'b0, ld = 1'b0;
    logic [W-1:0] ld_data = '0, opa = '0, opb = '0;
    logic [W-1:0] result;
    logic         carry_out;

    int           checks = 0;
    int           fails = 0;
    bit           done = 0;

    logic [W-1:0] m_res = '0;
    logic         m_c = 1'b0;

    always #2 clk = ~clk;

    addsub_loadreg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .en(en), .sub(sub), .ld(ld),
        .ld_data(ld_data), .opa(opa), .opb(opb),
        .result(result), .carry_out(carry_out)
    );

    task automatic compare(input string req);
        checks++;
        if (result !== m_res || carry_out !== m_c) begin
            fails++;
            $display("FAIL %s: got result=%h carry=%b, expected result=%h carry=%b",
                     req, result, carry_out, m_res, m_c);
        end
    endtask

    // Behavioural next-state, from the requirements.
    task automatic model_edge();
        int t;
        if (rst) begin
            m_res = '0; m_c = 1'b0;
        end else if (en) begin
            if (ld) begin
                m_res = ld_data; m_c = 1'b0;
            end else if (!sub) begin
                t = int'(opb) + int'(opa);
                m_res = W'(t); m_c = t[W];
            end else begin
                m_res = opb - opa;
                m_c = (opb >= opa);
            end
        end
    endtask

    task automatic cyc(input logic r, input logic e, input logic l, input logic s,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] d, input string req);
        @(negedge clk);
        rst = r; en = e; ld = l; sub = s; opa = a; opb = b; ld_data = d;
        @(posedge clk);
        model_edge();
        #1;
        compare(req);
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(1, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R1 reset");
        cyc(1, 1, 1, 1, 8'h12, 8'h34, 8'h56, "R1 reset with busy inputs");
        // R2 add
        cyc(0, 1, 0, 0, 8'h03, 8'h05, 8'h00, "R2 small add");
        cyc(0, 1, 0, 0, 8'h01, 8'hFF, 8'h00, "R2 wrap with carry");
        cyc(0, 1, 0, 0, 8'hFF, 8'hFF, 8'h00, "R2 max plus max");
        cyc(0, 1, 0, 0, 8'h55, 8'hAA, 8'h00, "R2 no carry full ones");
        // R3 subtract
        cyc(0, 1, 0, 1, 8'h01, 8'h00, 8'h00, "R3 zero minus one borrow");
        cyc(0, 1, 0, 1, 8'h3C, 8'h3C, 8'h00, "R3 equal operands");
        cyc(0, 1, 0, 1, 8'h00, 8'h7E, 8'h00, "R3 minus zero");
        cyc(0, 1, 0, 1, 8'h10, 8'h05, 8'h00, "R3 b below a");
        cyc(0, 1, 0, 1, 8'h05, 8'h10, 8'h00, "R3 b above a");
        // R4 load priority
        cyc(0, 1, 1, 0, 8'hFF, 8'h01, 8'hA5, "R4 load over add");
        cyc(0, 1, 0, 0, 8'hFF, 8'h02, 8'h00, "R2 carry set before load");
        cyc(0, 1, 1, 1, 8'h01, 8'h00, 8'h5A, "R4 load over sub clears carry");
        // R5 hold
        cyc(0, 1, 0, 0, 8'h80, 8'h80, 8'h00, "R2 carry set before hold");
        cyc(0, 0, 1, 0, 8'h11, 8'h22, 8'h33, "R5 hold with load");
        cyc(0, 0, 0, 1, 8'h01, 8'h00, 8'h00, "R5 hold with sub");
        // R6 no change between edges
        @(negedge clk);
        rst = 0; en = 1; ld = 1; ld_data = 8'hC3; opa = 8'h77; opb = 8'h66;
        #1 compare("R6 stable between edges");
        @(posedge clk); model_edge(); #1 compare("R6 load at edge");
        // R7 reset beats disabled enable
        cyc(0, 1, 0, 0, 8'hFF, 8'h01, 8'h00, "R2 set carry before reset");
        cyc(1, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R7 reset with enable low");
        // mixed random traffic, compared every clock
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv = $urandom;
            cyc(rv[0] & rv[1] & rv[2] & rv[3], rv[4] | rv[5], rv[6] & rv[7], rv[8],
                W'($urandom), W'($urandom), W'($urandom), "R2 R3 R4 R5 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule